// File: doc/BRIEF.md
# Latchable Parity Transceiver

This block sits between two byte-wide ports, called A and B. Each port carries eight data bits and one parity bit. Two active-low output enables pick the direction of transfer. Each direction has its own capture latch, which is either transparent or holding.

In the regenerate mode, the receiving port gets the sender's data together with a freshly computed parity bit. In the pass mode, the sender's own parity bit is forwarded unchanged. In both modes the block checks the sender's word against the chosen odd/even rule and reports the result on an active-low error flag.

When the latch on the receiving side is also transparent, the driven word is checked a second time, and the far-side flag reports that result. Each pad is modelled as three separate signals: an input, an output and an output-enable. The latches are modelled as registers loaded by the clock, so the block can be synthesised.

Top module: `parity_xcvr`

## Requirements
- R1: While `oe_ab_n` and `oe_ba_n` are both 1, `a_oe` and `b_oe` are 0 and both error flags are 1.
- R2: Generated parity is the XOR of the eight data bits when `odd_sel` is 0 and the XNOR of them when `odd_sel` is 1. In regenerate mode (`pass_sel` = 0) with only `oe_ab_n` low, `b_oe` is 1, `b_out` equals the A-side latch data and `b_par_out` equals the parity generated from that data.
- R3: With only `oe_ba_n` low, the B-to-A direction mirrors R2: `a_oe` is 1, and `a_out`/`a_par_out` carry the B-side latch data and its parity (generated or passed).
- R4: In pass mode (`pass_sel` = 1), the receiving parity output equals the sending side's latched parity bit, without change.
- R5: The near-side error flag (`err_a_n` when A sends, `err_b_n` when B sends) is 0 exactly when the data bits plus the parity bit fail the selected rule. The rule is an even count of ones when `odd_sel` = 0 and an odd count when `odd_sel` = 1. The flag is 1 otherwise.
- R6: While a direction's latch enable is 1, its latch is transparent: the outputs follow the current port input in the same cycle.
- R7: While a latch enable is 0, its latch presents the word held at the last rising clock edge at which that enable was 1. Later changes on the port input have no effect.
- R8: When the receiving side's latch enable is also 1, the driven word is checked by the R5 rule and the result appears on the far-side flag. If that enable is 0, the far-side flag stays 1.
- R9: With both output enables low, both `a_oe` and `b_oe` are 1. `b_out`/`b_par_out` carry the A-side latch word and `a_out`/`a_par_out` carry the B-side latch word, raw. Both error flags are 1.
- R10: A synchronous reset clears both held latch words to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that loads the latch registers |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 8 | Data arriving on port A |
| a_par_in | input | 1 | Parity arriving on port A |
| b_in | input | 8 | Data arriving on port B |
| b_par_in | input | 1 | Parity arriving on port B |
| oe_ab_n | input | 1 | Active-low enable for driving port B from A |
| oe_ba_n | input | 1 | Active-low enable for driving port A from B |
| pass_sel | input | 1 | 1 forwards the sender's parity, 0 regenerates it |
| le_ab | input | 1 | Transparent-enable of the A-side latch |
| le_ba | input | 1 | Transparent-enable of the B-side latch |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even parity |
| a_out | output | 8 | Data driven onto port A |
| a_par_out | output | 1 | Parity driven onto port A |
| a_oe | output | 1 | Port A driver enable |
| b_out | output | 8 | Data driven onto port B |
| b_par_out | output | 1 | Parity driven onto port B |
| b_oe | output | 1 | Port B driver enable |
| err_a_n | output | 1 | Active-low parity error seen on the A side |
| err_b_n | output | 1 | Active-low parity error seen on the B side |

## Verification
The assertions assume that the control inputs are stable across each rising edge. They also assume that a hold window starts only after reset has been low for at least one cycle, so the held value they compare against has been defined by a real capture. The stimulus changes every input just after a falling edge and samples one time unit later. Between stimulus and sampling there is no rising edge, except where a capture is intended. Reset is held for several cycles before any latch enable is dropped. Contention with both enables low is never checked; only the driven values are.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

    parameter int unsigned PTX_DW = 8;
    localparam int unsigned PTX_SIDES = 2;

    typedef struct packed {
        logic [PTX_DW-1:0] data;
        logic              par;
    } word_t;

    typedef enum logic [1:0] {
        DIR_OFF  = 2'd0,
        DIR_AB   = 2'd1,
        DIR_BA   = 2'd2,
        DIR_LOOP = 2'd3
    } dir_e;

    // parity bit that makes data+bit satisfy the rule (odd=1 -> odd ones)
    function automatic logic gen_parity(input logic [PTX_DW-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    // 1 when the word satisfies the selected rule
    function automatic logic word_ok(input word_t w, input logic odd);
        return ((^w.data) ^ w.par) == odd;
    endfunction

endpackage

// File: rtl/ptx_latch.sv
module ptx_latch
    import ptx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  le,
    input  word_t d,
    output word_t q
);
    word_t held;

    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else if (le)
            held <= d;
    end

    // transparent while enabled, holding otherwise
    assign q = le ? d : held;
endmodule

// File: rtl/ptx_dir_decode.sv
module ptx_dir_decode
    import ptx_pkg::*;
(
    input  logic oe_ab_n,
    input  logic oe_ba_n,
    output dir_e dir
);
    always_comb begin
        unique case ({oe_ab_n, oe_ba_n})
            2'b11:   dir = DIR_OFF;
            2'b01:   dir = DIR_AB;
            2'b10:   dir = DIR_BA;
            default: dir = DIR_LOOP;
        endcase
    end
endmodule

// File: rtl/ptx_lane.sv
module ptx_lane
    import ptx_pkg::*;
(
    input  word_t src,
    input  logic  active,
    input  logic  pass_sel,
    input  logic  odd_sel,
    input  logic  fb_le,
    output word_t drv,
    output logic  near_err_n,
    output logic  far_err_n
);
    logic gen;

    always_comb begin
        gen        = gen_parity(src.data, odd_sel);
        drv.data   = src.data;
        drv.par    = pass_sel ? src.par : gen;
        near_err_n = active ? word_ok(src, odd_sel) : 1'b1;
        far_err_n  = (active && fb_le) ? word_ok(drv, odd_sel) : 1'b1;
    end
endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr
    import ptx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PTX_DW-1:0] a_in,
    input  logic              a_par_in,
    input  logic [PTX_DW-1:0] b_in,
    input  logic              b_par_in,
    input  logic              oe_ab_n,
    input  logic              oe_ba_n,
    input  logic              pass_sel,
    input  logic              le_ab,
    input  logic              le_ba,
    input  logic              odd_sel,
    output logic [PTX_DW-1:0] a_out,
    output logic              a_par_out,
    output logic              a_oe,
    output logic [PTX_DW-1:0] b_out,
    output logic              b_par_out,
    output logic              b_oe,
    output logic              err_a_n,
    output logic              err_b_n
);
    // side 0 sends A->B, side 1 sends B->A
    dir_e                  dir;
    word_t [PTX_SIDES-1:0] side_in;
    word_t [PTX_SIDES-1:0] side_q;
    word_t [PTX_SIDES-1:0] side_drv;
    logic  [PTX_SIDES-1:0] le_v;
    logic  [PTX_SIDES-1:0] act_v;
    logic  [PTX_SIDES-1:0] near_n;
    logic  [PTX_SIDES-1:0] far_n;

    ptx_dir_decode u_dir (
        .oe_ab_n (oe_ab_n),
        .oe_ba_n (oe_ba_n),
        .dir     (dir)
    );

    assign side_in[0] = '{data: a_in, par: a_par_in};
    assign side_in[1] = '{data: b_in, par: b_par_in};
    assign le_v       = {le_ba, le_ab};
    assign act_v      = {dir == DIR_BA, dir == DIR_AB};

    for (genvar s = 0; s < PTX_SIDES; s++) begin : g_side
        ptx_latch u_lat (
            .clk (clk),
            .rst (rst),
            .le  (le_v[s]),
            .d   (side_in[s]),
            .q   (side_q[s])
        );
        ptx_lane u_lane (
            .src        (side_q[s]),
            .active     (act_v[s]),
            .pass_sel   (pass_sel),
            .odd_sel    (odd_sel),
            .fb_le      (le_v[PTX_SIDES-1-s]),
            .drv        (side_drv[s]),
            .near_err_n (near_n[s]),
            .far_err_n  (far_n[s])
        );
    end

    always_comb begin
        b_oe      = (dir == DIR_AB) || (dir == DIR_LOOP);
        a_oe      = (dir == DIR_BA) || (dir == DIR_LOOP);
        b_out     = side_q[0].data;
        b_par_out = (dir == DIR_AB) ? side_drv[0].par : side_q[0].par;
        a_out     = side_q[1].data;
        a_par_out = (dir == DIR_BA) ? side_drv[1].par : side_q[1].par;
        err_a_n   = near_n[0] & far_n[1];
        err_b_n   = near_n[1] & far_n[0];
    end
endmodule

// File: rtl/parity_xcvr_chk.sv
module parity_xcvr_chk
    import ptx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [PTX_DW-1:0] a_in,
    input logic              a_par_in,
    input logic              oe_ab_n,
    input logic              oe_ba_n,
    input logic              pass_sel,
    input logic              le_ab,
    input logic              odd_sel,
    input logic [PTX_DW-1:0] b_out,
    input logic              b_par_out,
    input logic              a_oe,
    input logic              b_oe,
    input logic              err_a_n,
    input logic              err_b_n
);
    logic ab_dir;
    assign ab_dir = !oe_ab_n && oe_ba_n;

    assert_isolated_R1: assert property (@(posedge clk) disable iff (rst)
        (oe_ab_n && oe_ba_n) |-> (!a_oe && !b_oe && err_a_n && err_b_n));

    assert_regen_rule_R2: assert property (@(posedge clk) disable iff (rst)
        (ab_dir && !pass_sel) |-> ((^{b_out, b_par_out}) == odd_sel));

    assert_pass_through_R4: assert property (@(posedge clk) disable iff (rst)
        (ab_dir && pass_sel && le_ab) |-> (b_par_out == a_par_in));

    assert_live_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (ab_dir && le_ab) |-> (err_a_n == ((^{a_in, a_par_in}) == odd_sel)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (ab_dir && !le_ab && $past(ab_dir) && $past(!le_ab) && $past(!rst))
            |-> $stable(b_out));

    assert_loop_R9: assert property (@(posedge clk) disable iff (rst)
        (!oe_ab_n && !oe_ba_n) |-> (a_oe && b_oe && err_a_n && err_b_n));
endmodule

bind parity_xcvr parity_xcvr_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .a_in      (a_in),
    .a_par_in  (a_par_in),
    .oe_ab_n   (oe_ab_n),
    .oe_ba_n   (oe_ba_n),
    .pass_sel  (pass_sel),
    .le_ab     (le_ab),
    .odd_sel   (odd_sel),
    .b_out     (b_out),
    .b_par_out (b_par_out),
    .a_oe      (a_oe),
    .b_oe      (b_oe),
    .err_a_n   (err_a_n),
    .err_b_n   (err_b_n)
);

// File: tb/tb_parity_xcvr.sv
module tb_parity_xcvr;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] a_in = '0, b_in = '0;
    logic       a_par_in = 1'b0, b_par_in = 1'b0;
    logic       oe_ab_n = 1'b1, oe_ba_n = 1'b1;
    logic       pass_sel = 1'b0, le_ab = 1'b0, le_ba = 1'b0, odd_sel = 1'b0;
    logic [7:0] a_out, b_out;
    logic       a_par_out, b_par_out, a_oe, b_oe, err_a_n, err_b_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    parity_xcvr dut (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_par_in(a_par_in), .b_in(b_in), .b_par_in(b_par_in),
        .oe_ab_n(oe_ab_n), .oe_ba_n(oe_ba_n), .pass_sel(pass_sel),
        .le_ab(le_ab), .le_ba(le_ba), .odd_sel(odd_sel),
        .a_out(a_out), .a_par_out(a_par_out), .a_oe(a_oe),
        .b_out(b_out), .b_par_out(b_par_out), .b_oe(b_oe),
        .err_a_n(err_a_n), .err_b_n(err_b_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ones(input logic [7:0] v);
        int c = 0;
        for (int i = 0; i < 8; i++) c += int'(v[i]);
        return c;
    endfunction

    // reference: parity bit that completes the rule
    function automatic logic ref_gen(input logic [7:0] v, input logic odd);
        return logic'((ones(v) % 2) != int'(odd));
    endfunction

    function automatic logic ref_ok(input logic [7:0] v, input logic p, input logic odd);
        return logic'(((ones(v) + int'(p)) % 2) == int'(odd));
    endfunction

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; le_ab = 1'b0; le_ba = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0; oe_ab_n = 1'b0; oe_ba_n = 1'b1; pass_sel = 1'b0; odd_sel = 1'b0;
        a_in = 8'hC3; a_par_in = 1'b1;
        #1;
        chk("R10 cleared data", int'(b_out), 0);
        chk("R10 cleared parity", int'(b_par_out), 0);
        chk("R10 flag on zero word", int'(err_a_n), 1);
        chk("R2 b_oe", int'(b_oe), 1);
        chk("R2 a_oe", int'(a_oe), 0);
    endtask

    task automatic t_isolate();
        @(negedge clk);
        oe_ab_n = 1'b1; oe_ba_n = 1'b1; le_ab = 1'b1; le_ba = 1'b1;
        a_in = 8'h01; a_par_in = 1'b0; odd_sel = 1'b0;
        #1;
        chk("R1 a_oe", int'(a_oe), 0);
        chk("R1 b_oe", int'(b_oe), 0);
        chk("R1 err_a_n", int'(err_a_n), 1);
        chk("R1 err_b_n", int'(err_b_n), 1);
    endtask

    // live sweep: both latches transparent, so far-side flag is produced
    task automatic t_sweep();
        for (int d = 0; d < 2; d++)
            for (int m = 0; m < 2; m++)
                for (int o = 0; o < 2; o++)
                    for (int p = 0; p < 2; p++)
                        for (int v = 0; v < 256; v++) begin
                            logic [7:0] dv;
                            logic ep, en, ef;
                            dv = 8'(v);
                            @(negedge clk);
                            le_ab = 1'b1; le_ba = 1'b1;
                            pass_sel = logic'(m); odd_sel = logic'(o);
                            oe_ab_n = logic'(d); oe_ba_n = logic'(1 - d);
                            if (d == 0) begin
                                a_in = dv; a_par_in = logic'(p); b_in = ~dv; b_par_in = ~logic'(p);
                            end else begin
                                b_in = dv; b_par_in = logic'(p); a_in = ~dv; a_par_in = ~logic'(p);
                            end
                            ep = (m == 1) ? logic'(p) : ref_gen(dv, logic'(o));
                            en = ref_ok(dv, logic'(p), logic'(o));
                            ef = (m == 1) ? en : 1'b1;
                            #1;
                            if (d == 0) begin
                                chk("R2/R6 b_out", int'(b_out), int'(dv));
                                chk("R2/R4 b_par_out", int'(b_par_out), int'(ep));
                                chk("R5 err_a_n", int'(err_a_n), int'(en));
                                chk("R8 err_b_n", int'(err_b_n), int'(ef));
                            end else begin
                                chk("R3/R6 a_out", int'(a_out), int'(dv));
                                chk("R3/R4 a_par_out", int'(a_par_out), int'(ep));
                                chk("R5 err_b_n", int'(err_b_n), int'(en));
                                chk("R8 err_a_n", int'(err_a_n), int'(ef));
                            end
                        end
    endtask

    task automatic t_hold();
        @(negedge clk);
        oe_ab_n = 1'b0; oe_ba_n = 1'b1; pass_sel = 1'b0; odd_sel = 1'b0;
        le_ab = 1'b1; le_ba = 1'b0; a_in = 8'h5A; a_par_in = 1'b1;
        @(negedge clk);
        le_ab = 1'b0; a_in = 8'hFF; a_par_in = 1'b0;
        #1;
        chk("R7 held data", int'(b_out), 8'h5A);
        chk("R7 held parity regen", int'(b_par_out), 0);
        chk("R7 held flag", int'(err_a_n), 0);
        @(negedge clk);
        a_in = 8'h00;
        #1;
        chk("R7 still held", int'(b_out), 8'h5A);
        pass_sel = 1'b1;
        #1;
        chk("R4 held parity passed", int'(b_par_out), 1);
    endtask

    task automatic t_no_feedback();
        @(negedge clk);
        oe_ab_n = 1'b0; oe_ba_n = 1'b1; pass_sel = 1'b1; odd_sel = 1'b1;
        le_ab = 1'b1; le_ba = 1'b0; a_in = 8'h03; a_par_in = 1'b0;
        #1;
        chk("R5 odd rule failure", int'(err_a_n), 0);
        chk("R8 far flag idle", int'(err_b_n), 1);
    endtask

    task automatic t_loop();
        @(negedge clk);
        oe_ab_n = 1'b0; oe_ba_n = 1'b0; pass_sel = 1'b0; odd_sel = 1'b0;
        le_ab = 1'b1; le_ba = 1'b1;
        a_in = 8'h3C; a_par_in = 1'b1; b_in = 8'hA5; b_par_in = 1'b1;
        #1;
        chk("R9 a_oe", int'(a_oe), 1);
        chk("R9 b_oe", int'(b_oe), 1);
        chk("R9 b_out", int'(b_out), 8'h3C);
        chk("R9 b_par_out", int'(b_par_out), 1);
        chk("R9 a_out", int'(a_out), 8'hA5);
        chk("R9 a_par_out", int'(a_par_out), 1);
        chk("R9 flags", int'({err_a_n, err_b_n}), 3);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_isolate();
        t_sweep();
        t_hold();
        t_no_feedback();
        t_loop();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule